// File: doc/BRIEF.md
# Flash Page Program Buffer

This block gathers the interlock writes of one flash program sequence and, on a start strobe, commits them to a small internal model of the flash array. Each write carries a byte address and a data word. The first write of a sequence fixes the page. Address bits 3:2 pick one of the four words in that page. Up to four distinct words can be pending at once. Writes to any other page are dropped until the sequence ends.

Programming obeys the flash rule that a bit can only go from 1 to 0, so the stored word becomes the old word ANDed with the buffered word. The commit is skipped without any signal in three cases: the page's block has its software lock set, either of the two hardware enables is low, or the block slot lies beyond the blocks that exist. The sequence still completes in the same way in all three cases.

After a start that finds pending words, `busy` stays high for a parameter-set number of cycles. Then `done` pulses for one cycle, the array shows the result, and the pending set is empty again. A combinational read port exposes any word of the array.

Top module: `fpb_page_prog`

## Requirements
- R1: After reset every array word reads all ones, `busy` is 0 and `done` is 0.
- R2: A committed word becomes its previous stored value ANDed with the buffered data, so a 0 is never turned back into a 1.
- R3: Address bits 3:2 select the word within the page. Up to four words are committed in one sequence. Words of the page that were not written keep their value.
- R4: The first accepted write latches the page (address bits above bit 3). Writes to a different page are ignored until the sequence completes.
- R5: If `sw_lock[b]` is 1 for the page's block b (the address bits above the page bits), the commit leaves the array unchanged.
- R6: The commit changes the array only when both `hw_en_a` and `hw_en_b` are 1.
- R7: A sequence addressed to a block slot with index at or above BLOCKS_PRESENT (slot 3 by default) is accepted and completes with `busy` and `done`, but the array is unchanged.
- R8: After an accepted start, `busy` is high for exactly PROG_CYCLES cycles. In the cycle after the last one, `done` is high for exactly one cycle, and the array already shows the result.
- R9: A start with no pending words is ignored. While `busy` is high, writes and starts are ignored.
- R10: A write presented in the same cycle as an accepted start joins that sequence. A start together with the first write of a sequence launches it.
- R11: When `done` pulses the pending set is empty, so the next write may latch a different page.
- R12: Repeated writes to the same word within a sequence keep only the last data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Interlock write strobe |
| wr_addr | input | ADDR_W (7) | Byte address of the write |
| wr_data | input | WORD_W (32) | Data of the write |
| start | input | 1 | Launch the program sequence |
| sw_lock | input | BLOCK_SLOTS (4) | Per-block software lock, 1 = locked |
| hw_en_a | input | 1 | First hardware program enable |
| hw_en_b | input | 1 | Second hardware program enable |
| rd_idx | input | IDX_W (5) | Array word index {block, page, word} |
| rd_data | output | WORD_W (32) | Array word at `rd_idx` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A write and a start can land in the same cycle. The write must then be merged into the sequence that is starting, even when it is the only write. The bench provokes this with a directed case on an empty buffer, and with random sequences whose last write shares its cycle with the start. A bench model that applies the write before judging the start predicts both the launch and the final array contents. Writes and starts sent while `busy` is high are a second overlap, and the same model expects them to leave no trace.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    localparam int PAGE_WORDS = 4;
    localparam int SEL_W      = 2;
    localparam int SEL_LSB    = 2;
    localparam int PAGE_LSB   = SEL_LSB + SEL_W;

    typedef logic [PAGE_WORDS-1:0] word_mask_t;

    function automatic word_mask_t sel_onehot(input logic [SEL_W-1:0] sel);
        sel_onehot = word_mask_t'(1) << sel;
    endfunction
endpackage

// File: rtl/fpb_seq.sv
module fpb_seq #(
    parameter int PROG_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic commit,
    output logic done
);
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (launch) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign commit = s_q.busy && (s_q.cnt == '0);
endmodule

// File: rtl/fpb_lock.sv
module fpb_lock #(
    parameter int BLOCK_SLOTS    = 4,
    parameter int BLOCKS_PRESENT = 3,
    parameter int PAGE_BITS      = 1,
    parameter int PG_W           = 3
) (
    input  logic [PG_W-1:0]        page_key,
    input  logic [BLOCK_SLOTS-1:0] sw_lock,
    input  logic                   hw_en_a,
    input  logic                   hw_en_b,
    output logic                   allow
);
    logic [BLOCK_SLOTS-1:0]    present;
    logic [BLOCK_SLOTS-1:0]    writable;
    logic [PG_W-PAGE_BITS-1:0] blk;

    for (genvar g = 0; g < BLOCK_SLOTS; g++) begin : g_slot
        assign present[g] = (g < BLOCKS_PRESENT);
    end

    assign writable = present & ~sw_lock;
    assign blk      = page_key[PG_W-1:PAGE_BITS];
    assign allow    = hw_en_a && hw_en_b && writable[blk];
endmodule

// File: rtl/fpb_array.sv
module fpb_array
    import fpb_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int PG_W        = 3,
    parameter int IDX_W       = PG_W + SEL_W,
    parameter int ARRAY_WORDS = 1 << IDX_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  commit,
    input  logic                                  allow,
    input  logic [PG_W-1:0]                       page_key,
    input  word_mask_t                            mask,
    input  logic [PAGE_WORDS-1:0][WORD_W-1:0]     wbuf,
    input  logic [IDX_W-1:0]                      rd_idx,
    output logic [WORD_W-1:0]                     rd_data
);
    logic [WORD_W-1:0] mem_d [ARRAY_WORDS];
    logic [WORD_W-1:0] mem_q [ARRAY_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (commit && allow) begin
            for (int w = 0; w < PAGE_WORDS; w++) begin
                if (mask[w]) begin
                    mem_d[IDX_W'({page_key, SEL_W'(w)})] =
                        mem_q[IDX_W'({page_key, SEL_W'(w)})] & wbuf[w];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_WORDS; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/fpb_page_prog.sv
module fpb_page_prog
    import fpb_pkg::*;
#(
    parameter int WORD_W          = 32,
    parameter int BLOCK_SLOTS     = 4,
    parameter int BLOCKS_PRESENT  = 3,
    parameter int PAGES_PER_BLOCK = 2,
    parameter int PROG_CYCLES     = 6,
    localparam int BLK_BITS  = $clog2(BLOCK_SLOTS),
    localparam int PAGE_BITS = $clog2(PAGES_PER_BLOCK),
    localparam int PG_W      = BLK_BITS + PAGE_BITS,
    localparam int ADDR_W    = PAGE_LSB + PG_W,
    localparam int IDX_W     = PG_W + SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   start,
    input  logic [BLOCK_SLOTS-1:0] sw_lock,
    input  logic                   hw_en_a,
    input  logic                   hw_en_b,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [WORD_W-1:0]      rd_data,
    output logic                   busy,
    output logic                   done
);
    typedef struct packed {
        word_mask_t                           mask;
        logic [PG_W-1:0]                      page;
        logic [PAGE_WORDS-1:0][WORD_W-1:0]    wbuf;
        logic                                 allow;
    } buf_t;

    buf_t b_d, b_q;

    logic [SEL_W-1:0] wr_sel;
    logic [PG_W-1:0]  wr_page;
    logic             same_page;
    logic             wr_take;
    logic [PG_W-1:0]  page_nx;
    word_mask_t       mask_nx;
    logic             launch;
    logic             allow_nx;
    logic             commit;
    word_mask_t       pend_mask;
    logic [1:0]       unused_lsb;

    assign unused_lsb = wr_addr[SEL_LSB-1:0];
    assign wr_sel     = wr_addr[PAGE_LSB-1:SEL_LSB];
    assign wr_page    = wr_addr[ADDR_W-1:PAGE_LSB];
    assign same_page  = (b_q.mask == '0) || (wr_page == b_q.page);
    assign wr_take    = wr_en && !busy && same_page;
    assign page_nx    = wr_take ? wr_page : b_q.page;
    assign mask_nx    = wr_take ? (b_q.mask | sel_onehot(wr_sel)) : b_q.mask;
    assign launch     = start && !busy && (mask_nx != '0);
    assign pend_mask  = b_q.mask;

    fpb_lock #(
        .BLOCK_SLOTS    (BLOCK_SLOTS),
        .BLOCKS_PRESENT (BLOCKS_PRESENT),
        .PAGE_BITS      (PAGE_BITS),
        .PG_W           (PG_W)
    ) u_lock (
        .page_key (page_nx),
        .sw_lock  (sw_lock),
        .hw_en_a  (hw_en_a),
        .hw_en_b  (hw_en_b),
        .allow    (allow_nx)
    );

    fpb_seq #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy),
        .commit (commit),
        .done   (done)
    );

    always_comb begin
        b_d      = b_q;
        b_d.mask = mask_nx;
        b_d.page = page_nx;
        if (wr_take) b_d.wbuf[wr_sel] = wr_data;
        if (launch)  b_d.allow = allow_nx;
        if (commit)  b_d.mask = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    fpb_array #(
        .WORD_W (WORD_W),
        .PG_W   (PG_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .allow    (b_q.allow),
        .page_key (b_q.page),
        .mask     (b_q.mask),
        .wbuf     (b_q.wbuf),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       wr_en,
    input logic       busy,
    input logic       done,
    input logic [3:0] pend_mask
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r9_empty_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !wr_en && pend_mask == 4'd0) |=> !busy);

    a_r11_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend_mask == 4'd0));
endmodule

bind fpb_page_prog fpb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_en     (wr_en),
    .busy      (busy),
    .done      (done),
    .pend_mask (pend_mask)
);

// File: tb/tb_fpb_page_prog.sv
module tb_fpb_page_prog;
    localparam int P = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [3:0]  sw_lock = '0;
    logic        hw_en_a = 1'b1;
    logic        hw_en_b = 1'b1;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [31:0] mdl_mem [32];
    logic [3:0]  mdl_mask;
    logic [2:0]  mdl_page;
    logic [31:0] mdl_buf [4];

    fpb_page_prog #(.PROG_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .sw_lock(sw_lock),
        .hw_en_a(hw_en_a), .hw_en_b(hw_en_b), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] mk_addr(input int blk, input int pg, input int w);
        return {2'(blk), 1'(pg), 2'(w), 2'b00};
    endfunction

    function automatic logic model_allow(input logic [2:0] page);
        return hw_en_a && hw_en_b && (page[2:1] < 2'd3) && !sw_lock[page[2:1]];
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [31:0] d);
        if (mdl_mask == 4'd0 || a[6:4] == mdl_page) begin
            mdl_mask       = mdl_mask | (4'd1 << a[3:2]);
            mdl_page       = a[6:4];
            mdl_buf[a[3:2]] = d;
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; start = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; start = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_array(input string req);
        idle_inputs();
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i);
            #1;
            chk(req, rd_data, mdl_mem[i]);
        end
        @(negedge clk);
    endtask

    // Launch with optional merged write, then run to completion and check.
    task automatic launch_seq(input string req, input bit with_wr,
                              input logic [6:0] a, input logic [31:0] d,
                              input bit noise);
        logic ok;
        logic al;
        int   cnt;
        @(negedge clk);
        start = 1'b1;
        wr_en = with_wr; wr_addr = a; wr_data = d;
        if (with_wr) model_write(a, d);
        ok = (mdl_mask != 4'd0);
        al = model_allow(mdl_page);
        @(negedge clk);
        idle_inputs();
        if (!ok) begin
            chk({req, " R9 empty start"}, {31'd0, busy}, 32'd0);
            return;
        end
        cnt = 0;
        while (busy && cnt < 100) begin
            if (noise) begin
                wr_en   = 1'b1;
                wr_addr = 7'($urandom);
                wr_data = 32'h0;
                start   = $urandom % 2;
            end
            cnt++;
            @(negedge clk);
        end
        idle_inputs();
        chk({req, " R8 busy length"}, 32'(cnt), 32'(P));
        chk({req, " R8 done pulse"}, {31'd0, done}, 32'd1);
        if (al) begin
            for (int w = 0; w < 4; w++)
                if (mdl_mask[w]) mdl_mem[{mdl_page, 2'(w)}] &= mdl_buf[w];
        end
        mdl_mask = 4'd0;
        rd_idx = {mdl_page, 2'b00};
        #1;
        chk({req, " R8 array at done"}, rd_data, mdl_mem[{mdl_page, 2'b00}]);
        @(negedge clk);
        chk({req, " R8 done single"}, {31'd0, done}, 32'd0);
        check_array(req);
    endtask

    initial begin
        #(20 * 150000);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seedv;
        seedv = $urandom(32'd1234);
        for (int i = 0; i < 32; i++) mdl_mem[i] = '1;
        mdl_mask = 4'd0;
        mdl_page = 3'd0;
        for (int w = 0; w < 4; w++) mdl_buf[w] = '0;

        repeat (3) @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_array("R1 array ones");

        // R2: two sequences on the same word only clear bits
        do_write(mk_addr(0, 0, 1), 32'hFFFF_0000);
        launch_seq("R2 first", 1'b0, '0, '0, 1'b0);
        do_write(mk_addr(0, 0, 1), 32'h0F0F_0F0F);
        launch_seq("R2 second", 1'b0, '0, '0, 1'b0);
        rd_idx = 5'd1; #1;
        chk("R2 and result", rd_data, 32'h0F0F_0000);

        // R3: all four words, R12: repeated word last wins, R4: other page ignored
        do_write(mk_addr(1, 1, 0), 32'hAAAA_AAAA);
        do_write(mk_addr(1, 1, 3), 32'h1111_1111);
        do_write(mk_addr(2, 0, 2), 32'h0000_0000);
        do_write(mk_addr(1, 1, 3), 32'h7777_7777);
        do_write(mk_addr(1, 1, 1), 32'h5555_5555);
        do_write(mk_addr(1, 1, 2), 32'h0000_FFFF);
        launch_seq("R3 four words", 1'b0, '0, '0, 1'b0);
        rd_idx = {3'b011, 2'd3}; #1;
        chk("R12 last write wins", rd_data, 32'h7777_7777);
        rd_idx = {3'b100, 2'd2}; #1;
        chk("R4 other page ignored", rd_data, 32'hFFFF_FFFF);

        // R5: software lock on block 1
        sw_lock = 4'b0010;
        do_write(mk_addr(1, 0, 0), 32'h0);
        launch_seq("R5 sw lock", 1'b0, '0, '0, 1'b0);
        sw_lock = 4'b0000;

        // R6: each hardware enable alone blocks
        hw_en_b = 1'b0;
        do_write(mk_addr(2, 1, 2), 32'h0);
        launch_seq("R6 hw b low", 1'b0, '0, '0, 1'b0);
        hw_en_b = 1'b1; hw_en_a = 1'b0;
        do_write(mk_addr(2, 1, 2), 32'h0);
        launch_seq("R6 hw a low", 1'b0, '0, '0, 1'b0);
        hw_en_a = 1'b1;

        // R7: nonexistent block slot 3
        do_write(mk_addr(3, 0, 0), 32'h0);
        launch_seq("R7 missing block", 1'b0, '0, '0, 1'b0);

        // R9: start with nothing pending
        launch_seq("R9 empty", 1'b0, '0, '0, 1'b0);

        // R10: first write merged with start; R11: new page after done; R9 noise while busy
        launch_seq("R10 merged first", 1'b1, mk_addr(0, 1, 2), 32'h1234_5678, 1'b1);
        do_write(mk_addr(2, 0, 0), 32'h00FF_00FF);
        launch_seq("R11 new page", 1'b1, mk_addr(2, 0, 3), 32'hF0F0_F0F0, 1'b0);
        rd_idx = {3'b100, 2'd3}; #1;
        chk("R10 merged word", rd_data, 32'hF0F0_F0F0);

        // Random sequences
        for (int s = 0; s < 50; s++) begin
            int nw;
            int bpg;
            int pg;
            bit mrg;
            sw_lock = 4'($urandom);
            hw_en_a = ($urandom % 6) != 0;
            hw_en_b = ($urandom % 6) != 0;
            nw  = $urandom % 5;
            bpg = $urandom % 8;
            for (int k = 0; k < nw; k++) begin
                pg = ($urandom % 4 == 0) ? int'($urandom % 8) : bpg;
                do_write({3'(pg), 2'($urandom), 2'b00}, $urandom | $urandom);
            end
            mrg = ($urandom % 3) == 0;
            launch_seq("R2 R10 random", mrg, {3'(bpg), 2'($urandom), 2'b00},
                       $urandom | $urandom, ($urandom % 2) == 1);
        end

        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule